// File: doc/BRIEF.md
# Chip-Level Interrupt Aggregation Controller

This block gathers a wide set of device-level interrupt lines and steers each one onto one of a smaller number of host channel outputs. The host channels then feed the per-core event inputs. Each source line is latched on its rising edge into a status bit. That bit stays set until software clears it by index. A status bit reaches a channel only when three things hold: the source's own enable is on, the channel it is mapped to has its enable on, and the global host enable is on.

Software configures the block through a small register bus. A single write carries an index, or an index plus a channel, and acts on that one entry:
- map a source to a channel;
- turn a source enable on or off;
- turn a channel enable on or off;
- force a status bit set;
- clear a status bit.

Two further addresses turn the global host enable on and off. A peek register reads back the status, the enable and the channel map of a selected source. Priority nesting is not provided. Each channel is the plain OR of its pending, enabled sources.

Top module: `irq_aggr_ctrl`

## Requirements
- R1: After synchronous reset, every status bit, source enable, channel enable and the global enable are 0, every map entry is channel 0, and `host_irq_out` is all zero.
- R2: A 0-to-1 transition on `sys_irq_in[i]` sets status bit i on the clock edge that first samples it high. A level that stays high does not set the bit again after it is cleared. Status is recorded whether or not the source is enabled.
- R3: Writing index i to address 7 clears status bit i at that edge. If a new rising edge on source i arrives in the same cycle, the bit stays set.
- R4: Writing index i to address 6 sets status bit i, so that the routing path can be exercised without the real source.
- R5: A write to address 8 with the source index in bits [15:0] and the channel in bits [23:16] assigns that source to that channel. A pending, enabled source then drives only its assigned channel.
- R6: Writing index i to address 2 enables source i, and writing it to address 3 disables it. A disabled source drives no channel, while its status remains visible.
- R7: Writing channel c to address 4 enables host channel c, and writing it to address 5 disables it. A disabled channel output is 0.
- R8: Any write to address 0 sets the global host enable, and any write to address 1 clears it. While it is clear, all channel outputs are 0. Reading address 0 returns the global enable in bit 0.
- R9: Each channel output is the OR of all pending, enabled sources mapped to it. Clearing one of them leaves the output high while another remains pending. Several channels can be active at once.
- R10: Writes whose source index is 160 or more, or whose map channel is 16 or more, change no state.
- R11: Writing a valid index to address 9 selects a source. Reading address 9 then returns its status in bit 0, its enable in bit 1, and its channel in bits [23:16]. All other read bits are 0, and other addresses read 0.
- R12: Register writes and input edges reach `host_irq_out` in the same cycle they are registered, with no further pipeline stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_irq_in | input | 160 | System interrupt lines, rising edge latched |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data (index, channel) |
| bus_rdata | output | 32 | Read data for the current address |
| host_irq_out | output | 16 | Host channel outputs |

## Verification
Every state change is due on the rising edge that samples the write or the input edge, and `host_irq_out` follows that state with no added register. An expected value therefore applies right after the edge that carries its stimulus. The bench drives stimulus after a falling edge, advances its reference model across the next rising edge, and compares outputs at the following falling edge. Readback is combinational from the registered state. A peek is checked one edge after the select write, on an idle bus cycle.

// File: rtl/icx_pkg.sv
package icx_pkg;

    // Register addresses; each write acts on one index carried in wdata.
    typedef enum logic [3:0] {
        RA_GLB_ON   = 4'd0,
        RA_GLB_OFF  = 4'd1,
        RA_SRC_ON   = 4'd2,
        RA_SRC_OFF  = 4'd3,
        RA_CH_ON    = 4'd4,
        RA_CH_OFF   = 4'd5,
        RA_STAT_SET = 4'd6,
        RA_STAT_CLR = 4'd7,
        RA_MAP      = 4'd8,
        RA_PEEK     = 4'd9
    } icx_addr_e;

    // Layout of the peek readback word.
    typedef struct packed {
        logic [7:0]  rsv_hi;
        logic [7:0]  chan;
        logic [13:0] rsv_lo;
        logic        src_en;
        logic        stat;
    } icx_peek_t;

    localparam int IDX_LSB = 0;
    localparam int IDX_BITS = 16;
    localparam int CH_LSB = 16;
    localparam int CH_BITS = 8;

    function automatic logic [IDX_BITS-1:0] get_idx(input logic [31:0] w);
        return w[IDX_LSB +: IDX_BITS];
    endfunction

    function automatic logic [CH_BITS-1:0] get_ch(input logic [31:0] w);
        return w[CH_LSB +: CH_BITS];
    endfunction

endpackage

// File: rtl/icx_status.sv
module icx_status #(
    parameter int N_SYS = 160
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_SYS-1:0]         sys_in,
    input  logic                     set_vld,
    input  logic                     clr_vld,
    input  logic [$clog2(N_SYS)-1:0] cmd_idx,
    output logic [N_SYS-1:0]         stat_q
);
    logic [N_SYS-1:0] prev_q;
    logic [N_SYS-1:0] rise_v;

    assign rise_v = sys_in & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= sys_in;
    end

    for (genvar i = 0; i < N_SYS; i++) begin : g_bit
        logic hit_set, hit_clr;
        assign hit_set = set_vld && (cmd_idx == i);
        assign hit_clr = clr_vld && (cmd_idx == i);
        always_ff @(posedge clk) begin
            if (rst) stat_q[i] <= 1'b0;
            else     stat_q[i] <= rise_v[i] | hit_set | (stat_q[i] & ~hit_clr);
        end
    end

    // R2
    rise_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (|rise_v) |=> ((stat_q & $past(rise_v)) == $past(rise_v)));

    // R3
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_vld && !rise_v[cmd_idx]) |=> !stat_q[$past(cmd_idx)]);

    // R3
    edge_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_vld && rise_v[cmd_idx]) |=> stat_q[$past(cmd_idx)]);

    // R4
    force_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_vld |=> stat_q[$past(cmd_idx)]);

endmodule

// File: rtl/icx_regs.sv
module icx_regs
    import icx_pkg::*;
#(
    parameter int N_SYS = 160,
    parameter int N_CH  = 16
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  bus_wr,
    input  logic [3:0]                            bus_addr,
    input  logic [31:0]                           bus_wdata,
    input  logic [N_SYS-1:0]                      stat,
    output logic [31:0]                           bus_rdata,
    output logic [N_SYS-1:0]                      src_en_q,
    output logic [N_CH-1:0]                       ch_en_q,
    output logic                                  glb_en_q,
    output logic [N_SYS-1:0][$clog2(N_CH)-1:0]    map_q,
    output logic                                  set_vld,
    output logic                                  clr_vld,
    output logic [$clog2(N_SYS)-1:0]              cmd_idx
);
    localparam int IW = $clog2(N_SYS);
    localparam int CW = $clog2(N_CH);

    icx_addr_e       addr_e;
    logic            idx_ok, ch_ok, chi_ok;
    logic [CW-1:0]   ch_idx;
    logic [IW-1:0]   sel_q;
    icx_peek_t       peek;

    assign addr_e  = icx_addr_e'(bus_addr);
    assign idx_ok  = get_idx(bus_wdata) < IDX_BITS'(N_SYS);
    assign chi_ok  = get_idx(bus_wdata) < IDX_BITS'(N_CH);
    assign ch_ok   = get_ch(bus_wdata) < CH_BITS'(N_CH);
    assign cmd_idx = bus_wdata[IW-1:0];
    assign ch_idx  = bus_wdata[CW-1:0];
    assign set_vld = bus_wr && (addr_e == RA_STAT_SET) && idx_ok;
    assign clr_vld = bus_wr && (addr_e == RA_STAT_CLR) && idx_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_en_q <= '0;
            ch_en_q  <= '0;
            glb_en_q <= 1'b0;
            map_q    <= '0;
            sel_q    <= '0;
        end else if (bus_wr) begin
            case (addr_e)
                RA_GLB_ON:  glb_en_q <= 1'b1;
                RA_GLB_OFF: glb_en_q <= 1'b0;
                RA_SRC_ON:  if (idx_ok) src_en_q[cmd_idx] <= 1'b1;
                RA_SRC_OFF: if (idx_ok) src_en_q[cmd_idx] <= 1'b0;
                RA_CH_ON:   if (chi_ok) ch_en_q[ch_idx] <= 1'b1;
                RA_CH_OFF:  if (chi_ok) ch_en_q[ch_idx] <= 1'b0;
                RA_MAP:     if (idx_ok && ch_ok) map_q[cmd_idx] <= bus_wdata[CH_LSB +: CW];
                RA_PEEK:    if (idx_ok) sel_q <= cmd_idx;
                default: ;
            endcase
        end
    end

    always_comb begin
        peek        = '0;
        peek.stat   = stat[sel_q];
        peek.src_en = src_en_q[sel_q];
        peek.chan   = CH_BITS'(map_q[sel_q]);
        bus_rdata   = '0;
        case (addr_e)
            RA_GLB_ON: bus_rdata[0] = glb_en_q;
            RA_PEEK:   bus_rdata = peek;
            default:   bus_rdata = '0;
        endcase
    end

    // R6
    src_on_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && addr_e == RA_SRC_ON && idx_ok) |=> src_en_q[$past(cmd_idx)]);

    // R6
    src_off_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && addr_e == RA_SRC_OFF && idx_ok) |=> !src_en_q[$past(cmd_idx)]);

    // R5
    map_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && addr_e == RA_MAP && idx_ok && ch_ok)
        |=> map_q[$past(cmd_idx)] == $past(bus_wdata[CH_LSB +: CW]));

    // R10
    bad_idx_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (addr_e == RA_SRC_ON || addr_e == RA_SRC_OFF) && !idx_ok)
        |=> $stable(src_en_q));

    // R10
    bad_map_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && addr_e == RA_MAP && !(idx_ok && ch_ok)) |=> $stable(map_q));

endmodule

// File: rtl/icx_route.sv
module icx_route #(
    parameter int N_SYS = 160,
    parameter int N_CH  = 16
) (
    input  logic [N_SYS-1:0]                   stat,
    input  logic [N_SYS-1:0]                   src_en,
    input  logic [N_SYS-1:0][$clog2(N_CH)-1:0] map,
    input  logic [N_CH-1:0]                    ch_en,
    input  logic                               glb_en,
    output logic [N_CH-1:0]                    host_out
);
    localparam int CW = $clog2(N_CH);

    logic [N_SYS-1:0] live;
    assign live = stat & src_en;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic any;
        always_comb begin
            any = 1'b0;
            for (int s = 0; s < N_SYS; s++) begin
                any = any | (live[s] && (map[s] == CW'(c)));
            end
        end
        assign host_out[c] = any & ch_en[c] & glb_en;
    end

endmodule

// File: rtl/irq_aggr_ctrl.sv
module irq_aggr_ctrl #(
    parameter int N_SYS = 160,
    parameter int N_CH  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SYS-1:0] sys_irq_in,
    input  logic             bus_wr,
    input  logic [3:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic [N_CH-1:0]  host_irq_out
);
    localparam int IW = $clog2(N_SYS);
    localparam int CW = $clog2(N_CH);

    logic [N_SYS-1:0]         stat;
    logic [N_SYS-1:0]         src_en;
    logic [N_CH-1:0]          ch_en;
    logic                     glb_en;
    logic [N_SYS-1:0][CW-1:0] map;
    logic                     set_vld, clr_vld;
    logic [IW-1:0]            cmd_idx;

    icx_regs #(.N_SYS(N_SYS), .N_CH(N_CH)) u_regs (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .stat(stat), .bus_rdata(bus_rdata),
        .src_en_q(src_en), .ch_en_q(ch_en), .glb_en_q(glb_en), .map_q(map),
        .set_vld(set_vld), .clr_vld(clr_vld), .cmd_idx(cmd_idx)
    );

    icx_status #(.N_SYS(N_SYS)) u_status (
        .clk(clk), .rst(rst), .sys_in(sys_irq_in),
        .set_vld(set_vld), .clr_vld(clr_vld), .cmd_idx(cmd_idx),
        .stat_q(stat)
    );

    icx_route #(.N_SYS(N_SYS), .N_CH(N_CH)) u_route (
        .stat(stat), .src_en(src_en), .map(map),
        .ch_en(ch_en), .glb_en(glb_en), .host_out(host_irq_out)
    );

    // R8
    glb_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !glb_en |-> (host_irq_out == '0));

    // R7
    ch_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (host_irq_out & ~ch_en) == '0);

    // R9
    no_live_chk: assert property (@(posedge clk) disable iff (rst)
        ((stat & src_en) == '0) |-> (host_irq_out == '0));

endmodule

// File: tb/tb_irq_aggr_ctrl.sv
`timescale 1ns/1ps
module tb_irq_aggr_ctrl;
    localparam int NS = 160;
    localparam int NC = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic [NS-1:0] sys_irq_in;
    logic          bus_wr;
    logic [3:0]    bus_addr;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic [NC-1:0] host_irq_out;

    irq_aggr_ctrl #(.N_SYS(NS), .N_CH(NC)) dut (
        .clk(clk), .rst(rst), .sys_irq_in(sys_irq_in),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .host_irq_out(host_irq_out)
    );

    always #4 clk = ~clk;

    int total = 0;
    int fails = 0;
    bit done = 0;

    // reference model
    logic [NS-1:0] m_stat, m_src, m_prev;
    logic [NC-1:0] m_ch;
    logic          m_glb;
    int            m_map [NS];
    int            m_sel;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [NC-1:0] exp_host();
        logic [NC-1:0] h = '0;
        for (int s = 0; s < NS; s++) if (m_stat[s] && m_src[s]) h[m_map[s]] = 1'b1;
        h &= m_ch;
        if (!m_glb) h = '0;
        return h;
    endfunction

    function automatic logic [31:0] exp_peek();
        logic [31:0] r = '0;
        r[0] = m_stat[m_sel];
        r[1] = m_src[m_sel];
        r[23:16] = 8'(m_map[m_sel]);
        return r;
    endfunction

    function automatic void model_reset();
        m_stat = '0; m_src = '0; m_prev = '0; m_ch = '0; m_glb = 1'b0; m_sel = 0;
        for (int s = 0; s < NS; s++) m_map[s] = 0;
    endfunction

    // one bus cycle: called at a falling edge, returns at the next falling edge
    task automatic cyc(input bit w, input logic [3:0] a, input logic [31:0] d, input string req);
        logic [NS-1:0] rise;
        int ii = int'(d[15:0]);
        int ch = int'(d[23:16]);
        bit iok = ii < NS;
        bus_wr = w; bus_addr = a; bus_wdata = d;
        rise = sys_irq_in & ~m_prev;
        m_prev = sys_irq_in;
        if (w) begin
            case (a)
                4'd0: m_glb = 1'b1;
                4'd1: m_glb = 1'b0;
                4'd2: if (iok) m_src[ii] = 1'b1;
                4'd3: if (iok) m_src[ii] = 1'b0;
                4'd4: if (ii < NC) m_ch[ii] = 1'b1;
                4'd5: if (ii < NC) m_ch[ii] = 1'b0;
                4'd6: if (iok) m_stat[ii] = 1'b1;
                4'd7: if (iok) m_stat[ii] = 1'b0;
                4'd8: if (iok && ch < NC) m_map[ii] = ch;
                4'd9: if (iok) m_sel = ii;
                default: ;
            endcase
        end
        m_stat = m_stat | rise;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        check(host_irq_out == exp_host(), req, 32'(host_irq_out), 32'(exp_host()));
    endtask

    task automatic peek(input int idx, input string req);
        cyc(1'b1, 4'd9, 32'(idx), req);
        bus_addr = 4'd9;
        #1;
        check(bus_rdata == exp_peek(), req, bus_rdata, exp_peek());
        cyc(1'b0, 4'd9, 32'd0, req);
    endtask

    task automatic wr(input logic [3:0] a, input int idx, input int ch, input string req);
        cyc(1'b1, a, {8'd0, 8'(ch), 16'(idx)}, req);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        rst = 1'b1; sys_irq_in = '0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(host_irq_out == '0, "R1", 32'(host_irq_out), 0);
        bus_addr = 4'd0; #1;
        check(bus_rdata == 0, "R1 glb", bus_rdata, 0);
        peek(77, "R1 peek");

        // R2 latch while disabled, raw readback
        sys_irq_in[5] = 1'b1;
        cyc(0, 0, 0, "R2 edge");
        peek(5, "R2 raw status w/o enable");
        // R5 map, R6/R7/R8 enables
        wr(4'd8, 5, 3, "R5 map");
        wr(4'd2, 5, 0, "R6 src on");
        wr(4'd4, 3, 0, "R7 ch on");
        check(host_irq_out == 0, "R8 glb off gates", 32'(host_irq_out), 0);
        wr(4'd0, 0, 0, "R8 glb on");
        check(host_irq_out == 16'h0008, "R5 R12 mapped ch", 32'(host_irq_out), 32'h8);
        bus_addr = 4'd0; #1;
        check(bus_rdata == 1, "R8 glb readback", bus_rdata, 1);
        // R3 clear; level stays high, no re-set (R2)
        wr(4'd7, 5, 0, "R3 clear");
        check(host_irq_out == 0, "R3 cleared", 32'(host_irq_out), 0);
        cyc(0, 0, 0, "R2 level no reset");
        // R3 clear and new edge same cycle
        sys_irq_in[5] = 1'b0;
        cyc(0, 0, 0, "R2 fall");
        sys_irq_in[5] = 1'b1;
        wr(4'd7, 5, 0, "R3 edge wins");
        check(host_irq_out == 16'h0008, "R3 edge wins", 32'(host_irq_out), 32'h8);
        // R9 OR of two sources
        wr(4'd8, 9, 3, "R9 map second");
        wr(4'd2, 9, 0, "R9 src on");
        wr(4'd6, 9, 0, "R4 force set");
        wr(4'd7, 5, 0, "R9 clear one");
        check(host_irq_out == 16'h0008, "R9 other keeps ch", 32'(host_irq_out), 32'h8);
        wr(4'd8, 150, 12, "R9 map far");
        wr(4'd2, 150, 0, "R9 src");
        wr(4'd4, 12, 0, "R9 ch");
        wr(4'd6, 150, 0, "R4 set");
        check(host_irq_out == 16'h1008, "R9 two channels", 32'(host_irq_out), 32'h1008);
        // R6 disable, R7 disable
        wr(4'd3, 150, 0, "R6 src off");
        check(host_irq_out == 16'h0008, "R6 src off", 32'(host_irq_out), 32'h8);
        peek(150, "R6 status still visible");
        wr(4'd5, 3, 0, "R7 ch off");
        check(host_irq_out == 0, "R7 ch off", 32'(host_irq_out), 0);
        // R10 out of range
        wr(4'd8, 9, 16, "R10 bad ch");
        wr(4'd8, 200, 1, "R10 bad idx");
        wr(4'd2, 160, 0, "R10 bad src");
        peek(9, "R10 map kept");
        wr(4'd1, 0, 0, "R8 glb off");

        // random phase
        for (int n = 0; n < 3000; n++) begin
            int op = $urandom % 10;
            int idx = $urandom % 172;
            int ch = $urandom % 18;
            if ($urandom % 2) begin
                int b = $urandom % NS;
                sys_irq_in[b] = ~sys_irq_in[b];
            end
            if (op == 4 || op == 5) idx = $urandom % 18;
            if (op == 9 || n % 5 == 0) peek(idx % 164, "R11 random peek");
            else wr(4'(op), idx, ch, "R9 random");
        end
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule